// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the software-facing side of a UART. Registers are reached through a simple word-decoded register bus. The block holds the control, FIFO-control, baud and millisecond registers, and it builds the status and test views from live state. It has one byte-stream port on each side:

- **Receive side.** Characters enter through a valid/ready handshake into a single-character holding buffer. A separate break strobe places an error word in that buffer.
- **Transmit side.** A one-byte holding register presents written bytes with a valid/ready handshake.

A single level interrupt is formed by gating status bits with enable bits. Serial bit timing, baud generation, deep FIFOs, DMA and modem lines live elsewhere. The baud registers only hold what software writes.

Reads are combinational: `rdata_o` is valid in the cycle that `req_i` is high. Any side effect of a read or write takes effect at the clock edge that ends that cycle. A register is selected by the byte address shifted right by two. The low two address bits are ignored.

Top module: `uart_reg_frontend`

## Requirements
- R1: After `rst_ni` the block reads as follows:
  - Control registers: control 1 (word 0x20) reads 0, control 2 (0x21) reads 0x0001, control 3 (0x22) reads 0x0700, control 4 (0x23) reads 0.
  - Other stored registers: FIFO control (0x24), modulator (0x2A) and millisecond (0x2C) read 0, and baud count (0x2B) reads 4.
  - Status and test registers: status 1 (0x25) reads 0x6040, status 2 (0x26) reads 0x4028, and test (0x2D) reads 0x0060.
  - Receive word (0x00) reads 0x4000.
  - Outputs: `irq_o` is 0, `rx_ready_o` is 1 and `tx_valid_o` is 0.
- R2: Reading word 0x00 while the buffer is full returns the buffered word with bit 15 set. That read empties the buffer, which does three things:
  - clears status 1 bit 9;
  - clears status 2 bit 0;
  - sets test bit 5.
  Reading word 0x00 while the buffer is empty returns the stored word without bit 15 and changes nothing.
- R3: `rx_ready_o` is the inverse of the buffer-full state. A character is taken only when `rx_valid_i` and `rx_ready_o` are both high. The character is stored zero-extended in the low byte and marks the buffer full. An offered character is ignored while the buffer is full.
- R4: A `rx_break_i` strobe does three things, even when the buffer is full:
  - loads the buffer with 0x5800 (bit 11 break, bit 12 framing, bit 14 error);
  - marks the buffer full;
  - sets status 2 bit 2.
- R5: A write to word 0x10 loads its low byte into the transmit holder only when two conditions hold: control 2 bit 2 is set, and no byte is pending. Otherwise the write is dropped. A pending byte stays on `tx_data_o` with `tx_valid_o` high until a cycle with `tx_ready_i` high.
- R6: The transmit-empty bits read 1 when no byte is pending and 0 while one is pending. These bits are status 1 bit 13, status 2 bits 14 and 3, and test bit 6.
- R7: Writes to status 1 change nothing. Writing a one to status 2 bit 2 clears the break flag. Every other bit written to status 2 is ignored.
- R8: Writing control 2 with bit 0 at zero performs a soft reset:
  - The values reset are control 1, control 3, modulator, baud count, the receive buffer, the break flag and the transmit holder. Each returns to its R1 value.
  - Control 4, FIFO control and millisecond keep their values.
  - Control 2 stores the written value with bit 0 forced to one.
- R9: `irq_o` is the OR of five terms:
  - control 1 bit 9 AND buffer full;
  - control 1 bit 13 AND transmit empty;
  - control 1 bit 6 AND transmit empty;
  - control 4 bit 3 AND transmit empty;
  - control 4 bit 0 AND buffer full.
  `irq_o` changes in the cycle after the register or buffer update.
- R10: Writes to the control, FIFO, modulator and millisecond words store only data bits 15:0. The baud words and the test word have special rules:
  - A write to word 0x29 stores into the baud count, and reads of 0x29 return 0.
  - Writes to word 0x2B have no effect.
  - Writes to the test word have no effect.
- R11: An access to a word outside {0x00, 0x10, 0x20-0x26, 0x29-0x2D} returns 0 and changes nothing. `err_o` is high during that request cycle and low for decoded accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid in the request cycle |
| err_o | output | 1 | High during an access to an undecoded word |
| rx_valid_i | input | 1 | Received character offered |
| rx_data_i | input | BYTE_W (8) | Received character |
| rx_ready_o | output | 1 | Holding buffer can take a character |
| rx_break_i | input | 1 | Break condition strobe |
| tx_valid_o | output | 1 | Transmit byte pending |
| tx_data_o | output | BYTE_W (8) | Transmit byte |
| tx_ready_i | input | 1 | Transmit side takes the byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 12-bit address, a 32-bit data bus and an 8-bit character. With a 12-bit address there are only 64 words below 0x100, so the bench reads every one of them and predicts `err_o` from the decoded set. The interrupt sweep covers all 32 combinations of the five enable bits in each of the four combinations of buffer-full and transmit-pending. Every expected interrupt level is computed from the R9 formula.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned REG_W = 16;

  // word indices (byte address >> 2)
  localparam int unsigned W_RXD  = 'h00;
  localparam int unsigned W_TXD  = 'h10;
  localparam int unsigned W_CTL1 = 'h20;
  localparam int unsigned W_CTL2 = 'h21;
  localparam int unsigned W_CTL3 = 'h22;
  localparam int unsigned W_CTL4 = 'h23;
  localparam int unsigned W_FIFO = 'h24;
  localparam int unsigned W_STS1 = 'h25;
  localparam int unsigned W_STS2 = 'h26;
  localparam int unsigned W_BINC = 'h29;
  localparam int unsigned W_BMOD = 'h2A;
  localparam int unsigned W_BCNT = 'h2B;
  localparam int unsigned W_MSEC = 'h2C;
  localparam int unsigned W_TEST = 'h2D;

  // status 1 / control 1 shared enable positions
  localparam int unsigned S1_TXRDY  = 13;
  localparam int unsigned S1_RXRDY  = 9;
  localparam int unsigned S1_RTS    = 14;
  localparam int unsigned S1_RXIDLE = 6;
  // status 2
  localparam int unsigned S2_TXFE   = 14;
  localparam int unsigned S2_DCD    = 5;
  localparam int unsigned S2_TXDONE = 3;
  localparam int unsigned S2_BRK    = 2;
  localparam int unsigned S2_DRDY   = 0;
  // test
  localparam int unsigned T_RXEMPTY = 5;
  localparam int unsigned T_TXEMPTY = 6;
  // control bits
  localparam int unsigned C1_TXEIE = 6;
  localparam int unsigned C2_SRST  = 0;
  localparam int unsigned C2_TXEN  = 2;
  localparam int unsigned C4_TCIE  = 3;
  localparam int unsigned C4_DRIE  = 0;
  // receive word flags
  localparam int unsigned RW_CHARRDY = 15;
  localparam int unsigned RW_ERR     = 14;
  localparam int unsigned RW_FRM     = 12;
  localparam int unsigned RW_BRK     = 11;

  localparam logic [REG_W-1:0] CTL3_RST  = 16'h0700;
  localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
  localparam logic [REG_W-1:0] RXW_RST   = REG_W'(1) << RW_ERR;
  localparam logic [REG_W-1:0] RXW_BREAK = (REG_W'(1) << RW_ERR) | (REG_W'(1) << RW_FRM)
                                         | (REG_W'(1) << RW_BRK);

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RXD, SEL_TXD, SEL_CTL1, SEL_CTL2, SEL_CTL3, SEL_CTL4, SEL_FIFO,
    SEL_STS1, SEL_STS2, SEL_BINC, SEL_BMOD, SEL_BCNT, SEL_MSEC, SEL_TEST
  } reg_sel_e;
endpackage

// File: rtl/uart_fe_rxbuf.sv
module uart_fe_rxbuf
  import uart_fe_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              pop_i,
  input  logic              brk_clr_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_break_i,
  output logic              rx_ready_o,
  output logic              full_o,
  output logic [REG_W-1:0]  word_o,
  output logic              brk_o
);
  localparam int unsigned PAD_W = REG_W - BYTE_W;

  logic             full_q, brk_q;
  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      brk_q  <= 1'b0;
      word_q <= RXW_RST;
    end else if (clear_i) begin
      full_q <= 1'b0;
      brk_q  <= 1'b0;
      word_q <= RXW_RST;
    end else begin
      if (rx_break_i) begin
        full_q <= 1'b1;
        word_q <= RXW_BREAK;
      end else if (rx_valid_i && !full_q) begin
        full_q <= 1'b1;
        word_q <= {{PAD_W{1'b0}}, rx_data_i};
      end else if (pop_i && full_q) begin
        full_q <= 1'b0;
      end
      if (rx_break_i)     brk_q <= 1'b1;
      else if (brk_clr_i) brk_q <= 1'b0;
    end
  end

  assign rx_ready_o = !full_q;
  assign full_o     = full_q;
  assign word_o     = word_q;
  assign brk_o      = brk_q;

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && !clear_i && !rx_break_i)
      |=> (full_o && word_o[BYTE_W-1:0] == $past(rx_data_i)));
  p_pop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && full_o && !rx_break_i && !clear_i) |=> !full_o);
  p_break_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_i && !clear_i) |=> (full_o && brk_o && word_o == RXW_BREAK));
endmodule

// File: rtl/uart_fe_txhold.sv
module uart_fe_txhold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              empty_o
);
  logic              pend_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (clear_i) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (tx_ready_i) pend_q <= 1'b0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      data_q <= data_i;
    end
  end

  assign tx_valid_o = pend_q;
  assign tx_data_o  = data_q;
  assign empty_o    = !pend_q;

  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !clear_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq
  import uart_fe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] sts1_i,
  input  logic [REG_W-1:0] sts2_i,
  input  logic [REG_W-1:0] ctl1_i,
  input  logic [REG_W-1:0] ctl4_i,
  output logic             irq_o
);
  localparam logic [REG_W-1:0] S1_MASK = (REG_W'(1) << S1_TXRDY) | (REG_W'(1) << S1_RXRDY);
  localparam logic [REG_W-1:0] C4_MASK = (REG_W'(1) << C4_TCIE) | (REG_W'(1) << C4_DRIE);

  logic [REG_W-1:0] s2_en;

  // control 4 enables share bit positions with the status 2 bits they gate
  always_comb begin
    s2_en = ctl4_i & C4_MASK;
    s2_en[S2_TXFE] = ctl1_i[C1_TXEIE];
  end

  assign irq_o = |(sts1_i & ctl1_i & S1_MASK) || |(sts2_i & s2_en);

  p_irq_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl1_i & S1_MASK) == '0 && !ctl1_i[C1_TXEIE] && (ctl4_i & C4_MASK) == '0) |-> !irq_o);
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BYTE_W     = 8,
  parameter bit          ERR_PULSE  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  input  logic              rx_break_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam int unsigned RPAD_W = DATA_W - REG_W;

  reg_sel_e          sel;
  logic [WIDX_W-1:0] widx;
  logic [REG_W-1:0]  wd16, rd16;
  logic              wr, rd, sreset;

  logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, fifo_q, bmod_q, bcnt_q, msec_q;
  logic [REG_W-1:0] sts1, sts2, test, rx_word;
  logic             rx_full, brk_det, tx_empty;

  assign widx = addr_i[ADDR_W-1:2];
  assign wd16 = wdata_i[REG_W-1:0];
  assign wr   = req_i && we_i;
  assign rd   = req_i && !we_i;

  always_comb begin
    case (widx)
      WIDX_W'(W_RXD):  sel = SEL_RXD;
      WIDX_W'(W_TXD):  sel = SEL_TXD;
      WIDX_W'(W_CTL1): sel = SEL_CTL1;
      WIDX_W'(W_CTL2): sel = SEL_CTL2;
      WIDX_W'(W_CTL3): sel = SEL_CTL3;
      WIDX_W'(W_CTL4): sel = SEL_CTL4;
      WIDX_W'(W_FIFO): sel = SEL_FIFO;
      WIDX_W'(W_STS1): sel = SEL_STS1;
      WIDX_W'(W_STS2): sel = SEL_STS2;
      WIDX_W'(W_BINC): sel = SEL_BINC;
      WIDX_W'(W_BMOD): sel = SEL_BMOD;
      WIDX_W'(W_BCNT): sel = SEL_BCNT;
      WIDX_W'(W_MSEC): sel = SEL_MSEC;
      WIDX_W'(W_TEST): sel = SEL_TEST;
      default:         sel = SEL_NONE;
    endcase
  end

  assign sreset = wr && sel == SEL_CTL2 && !wd16[C2_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_q <= '0;
      ctl2_q <= REG_W'(1) << C2_SRST;
      ctl3_q <= CTL3_RST;
      ctl4_q <= '0;
      fifo_q <= '0;
      bmod_q <= '0;
      bcnt_q <= BCNT_RST;
      msec_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CTL1: ctl1_q <= wd16;
        SEL_CTL2: begin
          if (!wd16[C2_SRST]) begin
            ctl1_q <= '0;
            ctl3_q <= CTL3_RST;
            bmod_q <= '0;
            bcnt_q <= BCNT_RST;
          end
          ctl2_q <= wd16 | (REG_W'(1) << C2_SRST);
        end
        SEL_CTL3: ctl3_q <= wd16;
        SEL_CTL4: ctl4_q <= wd16;
        SEL_FIFO: fifo_q <= wd16;
        SEL_BINC: bcnt_q <= wd16;
        SEL_BMOD: bmod_q <= wd16;
        SEL_MSEC: msec_q <= wd16;
        default: ;
      endcase
    end
  end

  uart_fe_rxbuf #(.BYTE_W(BYTE_W)) u_rxbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (sreset),
    .pop_i      (rd && sel == SEL_RXD),
    .brk_clr_i  (wr && sel == SEL_STS2 && wd16[S2_BRK]),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rx_break_i (rx_break_i),
    .rx_ready_o (rx_ready_o),
    .full_o     (rx_full),
    .word_o     (rx_word),
    .brk_o      (brk_det)
  );

  uart_fe_txhold #(.BYTE_W(BYTE_W)) u_txhold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (sreset),
    .load_i     (wr && sel == SEL_TXD && ctl2_q[C2_TXEN]),
    .data_i     (wdata_i[BYTE_W-1:0]),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .empty_o    (tx_empty)
  );

  always_comb begin
    sts1 = '0;
    sts1[S1_TXRDY]  = tx_empty;
    sts1[S1_RXRDY]  = rx_full;
    sts1[S1_RTS]    = 1'b1;
    sts1[S1_RXIDLE] = 1'b1;
    sts2 = '0;
    sts2[S2_TXFE]   = tx_empty;
    sts2[S2_TXDONE] = tx_empty;
    sts2[S2_DCD]    = 1'b1;
    sts2[S2_BRK]    = brk_det;
    sts2[S2_DRDY]   = rx_full;
    test = '0;
    test[T_RXEMPTY] = !rx_full;
    test[T_TXEMPTY] = tx_empty;
  end

  uart_fe_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sts1_i (sts1),
    .sts2_i (sts2),
    .ctl1_i (ctl1_q),
    .ctl4_i (ctl4_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (sel)
      SEL_RXD:  rd16 = rx_word | (REG_W'(rx_full) << RW_CHARRDY);
      SEL_CTL1: rd16 = ctl1_q;
      SEL_CTL2: rd16 = ctl2_q;
      SEL_CTL3: rd16 = ctl3_q;
      SEL_CTL4: rd16 = ctl4_q;
      SEL_FIFO: rd16 = fifo_q;
      SEL_STS1: rd16 = sts1;
      SEL_STS2: rd16 = sts2;
      SEL_BMOD: rd16 = bmod_q;
      SEL_BCNT: rd16 = bcnt_q;
      SEL_MSEC: rd16 = msec_q;
      SEL_TEST: rd16 = test;
      default:  rd16 = '0;
    endcase
  end
  assign rdata_o = {{RPAD_W{1'b0}}, rd16};

  generate
    if (ERR_PULSE) begin : g_err
      assign err_o = req_i && sel == SEL_NONE;
    end else begin : g_no_err
      assign err_o = 1'b0;
    end
  endgenerate

  p_srst_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_CTL2) |=> ctl2_q[C2_SRST]);
  p_soft_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset |=> (ctl1_q == '0 && ctl3_q == CTL3_RST && bcnt_q == BCNT_RST && !tx_valid_o));
  p_undecoded_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_NONE) |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(ctl3_q)
                                 && $stable(ctl4_q) && $stable(bcnt_q)));
endmodule

// File: tb/sim_uart_reg_frontend.sv
module sim_uart_reg_frontend;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        err_o, rx_valid_i = 0, rx_ready_o, rx_break_i = 0;
  logic [7:0]  rx_data_i = '0, tx_data_o;
  logic        tx_valid_o, tx_ready_i = 0, irq_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_reg_frontend u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .rx_valid_i(rx_valid_i),
    .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o), .rx_break_i(rx_break_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = 12'(w << 2); wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input int w, output logic [31:0] d, output logic e);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = 12'(w << 2);
    #1; d = rdata_o; e = err_o;
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic rchk(input string tag, input int w, input logic [31:0] exp);
    logic [31:0] d; logic e;
    rd(w, d, e);
    chk(tag, d, exp);
  endtask

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    rx_valid_i = 1; rx_data_i = c;
    @(negedge clk);
    rx_valid_i = 0;
  endtask

  task automatic brk();
    @(negedge clk);
    rx_break_i = 1;
    @(negedge clk);
    rx_break_i = 0;
  endtask

  task automatic irq_sweep(input bit rxf, input bit txp);
    for (int e = 0; e < 32; e++) begin
      logic exp;
      wr('h20, (32'(e & 1) << 9) | (32'((e >> 1) & 1) << 13) | (32'((e >> 2) & 1) << 6));
      wr('h23, (32'((e >> 3) & 1) << 3) | 32'((e >> 4) & 1));
      exp = ((e[0] | e[4]) & rxf) | ((e[1] | e[2] | e[3]) & !txp);
      chk($sformatf("R9 irq e=%0d rx=%0d tx=%0d", e, rxf, txp), 32'(irq_o), 32'(exp));
    end
  endtask

  function automatic bit decoded(input int w);
    return w == 'h00 || w == 'h10 || (w >= 'h20 && w <= 'h26) || (w >= 'h29 && w <= 'h2D);
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rx_ready", 32'(rx_ready_o), 1);
    chk("R1 tx_valid", 32'(tx_valid_o), 0);
    rchk("R1 ctl1", 'h20, 0);       rchk("R1 ctl2", 'h21, 1);
    rchk("R1 ctl3", 'h22, 'h700);   rchk("R1 ctl4", 'h23, 0);
    rchk("R1 fifo", 'h24, 0);       rchk("R1 sts1", 'h25, 'h6040);
    rchk("R1 sts2", 'h26, 'h4028);  rchk("R1 bmod", 'h2A, 0);
    rchk("R1 bcnt", 'h2B, 4);       rchk("R1 msec", 'h2C, 0);
    rchk("R1 test", 'h2D, 'h60);    rchk("R1 rxd", 'h00, 'h4000);

    // R11 sweep of the low word space
    for (int w = 0; w < 64; w++) begin
      rd(w, d, e);
      chk($sformatf("R11 err w=0x%0h", w), 32'(e), 32'(!decoded(w)));
      if (!decoded(w)) chk($sformatf("R11 rdata w=0x%0h", w), d, 0);
    end
    wr('h30, 32'hFFFF_FFFF);
    wr('h3FF, 32'hFFFF_FFFF);
    rchk("R11 ctl1 untouched", 'h20, 0);
    rchk("R11 ctl3 untouched", 'h22, 'h700);
    rchk("R11 bcnt untouched", 'h2B, 4);

    // R10 masking and baud words
    wr('h22, 32'hABCD_1234); rchk("R10 ctl3 low16", 'h22, 'h1234);
    wr('h24, 32'hFFFF_0081); rchk("R10 fifo low16", 'h24, 'h81);
    wr('h2C, 32'h0001_0077); rchk("R10 msec low16", 'h2C, 'h77);
    wr('h2A, 32'h0003_0022); rchk("R10 bmod low16", 'h2A, 'h22);
    wr('h29, 32'h0005_0099); rchk("R10 binc reads zero", 'h29, 0);
    rchk("R10 binc lands in bcnt", 'h2B, 'h99);
    wr('h2B, 32'hBEEF);      rchk("R10 bcnt write ignored", 'h2B, 'h99);
    wr('h2D, 32'h0);         rchk("R10 test write ignored", 'h2D, 'h60);

    // R7 status 1 writes ignored
    wr('h25, 32'hFFFF);      rchk("R7 sts1 unchanged", 'h25, 'h6040);

    // R2 / R3 receive path
    send(8'hA5);
    chk("R3 rx_ready low when full", 32'(rx_ready_o), 0);
    rchk("R2 sts1 full", 'h25, 'h6240);
    rchk("R2 sts2 full", 'h26, 'h4029);
    rchk("R2 test full", 'h2D, 'h40);
    send(8'h77);
    rchk("R3 offered char ignored", 'h00, 'h80A5);
    rchk("R2 sts1 after pop", 'h25, 'h6040);
    rchk("R2 sts2 after pop", 'h26, 'h4028);
    rchk("R2 test after pop", 'h2D, 'h60);
    rchk("R2 empty read no charrdy", 'h00, 'h00A5);
    chk("R3 rx_ready back", 32'(rx_ready_o), 1);

    // R4 break
    brk();
    rchk("R4 sts2 break", 'h26, 'h402D);
    rchk("R4 break word", 'h00, 'hD800);
    send(8'h3C);
    brk();
    rchk("R4 break overrides full", 'h00, 'hD800);
    rchk("R4 brk flag kept", 'h26, 'h402C);

    // R7 status 2 write-one-to-clear
    wr('h26, 32'hFFFB);      rchk("R7 sts2 other bits ignored", 'h26, 'h402C);
    wr('h26, 32'h0004);      rchk("R7 sts2 brk cleared", 'h26, 'h4028);

    // R5 / R6 transmit path
    wr('h10, 32'h55);
    chk("R5 tx dropped when disabled", 32'(tx_valid_o), 0);
    wr('h21, 32'h5);
    wr('h10, 32'h1A5);
    chk("R5 tx valid", 32'(tx_valid_o), 1);
    chk("R5 tx low byte", 32'(tx_data_o), 'hA5);
    rchk("R6 sts1 pending", 'h25, 'h4040);
    rchk("R6 sts2 pending", 'h26, 'h0020);
    rchk("R6 test pending", 'h2D, 'h20);
    wr('h10, 32'h33);
    chk("R5 write while pending dropped", 32'(tx_data_o), 'hA5);
    chk("R5 still valid", 32'(tx_valid_o), 1);
    @(negedge clk); tx_ready_i = 1;
    @(negedge clk); tx_ready_i = 0;
    chk("R5 handshake done", 32'(tx_valid_o), 0);
    rchk("R6 sts1 empty again", 'h25, 'h6040);

    // R9 enable sweep over four states
    irq_sweep(0, 0);
    send(8'h11);
    irq_sweep(1, 0);
    wr('h10, 32'h22);
    irq_sweep(1, 1);
    rchk("R2 pop before sweep", 'h00, 'h8011);
    irq_sweep(0, 1);

    // R8 soft reset with pending state
    wr('h20, 32'h1234); wr('h22, 32'h5555); wr('h23, 32'h9);
    wr('h29, 32'h77);
    send(8'h44); brk();
    wr('h21, 32'h4);
    rchk("R8 ctl2 srst forced", 'h21, 'h5);
    rchk("R8 ctl1 reset", 'h20, 0);
    rchk("R8 ctl3 reset", 'h22, 'h700);
    rchk("R8 bmod reset", 'h2A, 0);
    rchk("R8 bcnt reset", 'h2B, 4);
    rchk("R8 ctl4 kept", 'h23, 'h9);
    rchk("R8 fifo kept", 'h24, 'h81);
    rchk("R8 msec kept", 'h2C, 'h77);
    rchk("R8 sts1", 'h25, 'h6040);
    rchk("R8 sts2", 'h26, 'h4028);
    chk("R8 tx discarded", 32'(tx_valid_o), 0);
    chk("R9 irq from ctl4 after soft reset", 32'(irq_o), 1);
    rchk("R8 rx word reset", 'h00, 'h4000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule